// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

A one-bit-wide read-only store that streams a fixed bit pattern to a master device, one bit per rising clock edge. An internal pointer walks from address zero to the last address. When the store runs dry, the block pulls its chain-enable output low so that the next device in a daisy chain can take over the shared data line without losing a bit.

A combined reset/output-enable input clears the pointer and silences the output. Its active level is chosen by a parameter. A chip-enable input freezes the pointer and puts the block into standby. When the chip-enable returns, a read that was paused picks up from the bit where it stopped.

The stored content is computed from the address and a seed parameter, so no memory array or file is needed. The depth can therefore be large.

Top module: `serial_cfg_rom`

## Requirements
- R1: On a rising edge where ce_ni is 0, the reset/output-enable input is inactive and fewer than DEPTH bits have been read, the pointer advances by one.
- R2: With RST_HIGH=1 (the default), rstoe_i=1 asserts reset; with RST_HIGH=0, rstoe_i=0 asserts it. While reset is asserted, data_oe_o is 0, ceo_no is 1, and the pointer is zero after the next edge, so the following read starts at address 0.
- R3: While ce_ni is 1, standby_o is 1, data_oe_o is 0, ceo_no is 1 and the pointer keeps its value.
- R4: After all DEPTH bits have been read, the pointer stays at the end: data_oe_o stays 0 on every further edge until reset.
- R5: ceo_no is 0 exactly when ce_ni is 0, reset is inactive and all DEPTH bits have been read; otherwise it is 1.
- R6: ceo_no falls in the same cycle that the last bit is presented. On the next edge data_oe_o drops and a cascaded device presents its first bit, so at most one device drives at a time and the stream has no gap.
- R7: If ce_ni rises in the middle of a read and later falls, the next bit presented is the one after the last bit presented before the pause.
- R8: The bit at address a equals the XOR of all 32 bits of (a ^ (a >> 1) ^ SEED). data_o is 0 whenever data_oe_o is 0.
- R9: The edge that advances the pointer from a to a+1 makes data_o show the bit at address a, with data_oe_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ce_ni | input | 1 | Active-low chip enable |
| rstoe_i | input | 1 | Reset/output enable; active level set by RST_HIGH |
| data_o | output | 1 | Serial data bit |
| data_oe_o | output | 1 | High when data_o would be driven |
| ceo_no | output | 1 | Active-low chain enable to the next device |
| standby_o | output | 1 | High in low-power standby |

## Verification
The assertions assume that ce_ni and rstoe_i are synchronous to clk_i and stable around each rising edge. They also assume that a cascaded device takes its ce_ni directly from the previous ceo_no. The bench changes every input one nanosecond after a rising edge and wires the two chained instances exactly that way. Random chip-enable pauses are therefore seen whole by both devices. A mid-stream reset is applied only while the clock is running and the power-on reset is released.

// File: rtl/serial_cfg_rom_pkg.sv
package serial_cfg_rom_pkg;
  // stored pattern: parity of a Gray-coded address mixed with a seed
  function automatic logic rom_bit(input logic [31:0] addr, input logic [31:0] seed);
    return ^(addr ^ (addr >> 1) ^ seed);
  endfunction
endpackage

// File: rtl/serial_cfg_rom_ctrl.sv
module serial_cfg_rom_ctrl #(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic ce_ni,
  input  logic rstoe_i,
  output logic ce_act_o,
  output logic rst_act_o,
  output logic standby_o
);
  generate
    if (RST_HIGH) begin : g_rst_high
      assign rst_act_o = rstoe_i;
    end else begin : g_rst_low
      assign rst_act_o = ~rstoe_i;
    end
  endgenerate

  assign ce_act_o  = ~ce_ni;
  assign standby_o = ce_ni;
endmodule

// File: rtl/serial_cfg_rom_addr.sv
module serial_cfg_rom_addr #(
  parameter int unsigned DEPTH = 18144,
  localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_act_i,
  input  logic          rst_act_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic          count_en_o
);
  localparam logic [AW-1:0] TERM = AW'(DEPTH);

  logic [AW-1:0] addr_q;

  assign done_o     = (addr_q == TERM);
  assign count_en_o = ce_act_i & ~rst_act_i & ~done_o;
  assign addr_o     = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (rst_act_i)  addr_q <= '0;
    else if (count_en_o) addr_q <= addr_q + 1'b1;
  end

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_act_i && !rst_act_i && addr_q < TERM) |=> addr_q == $past(addr_q) + 1'b1);
  p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act_i |=> addr_q == '0);
  p_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_act_i && !rst_act_i) |=> $stable(addr_q));
  p_saturate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q == TERM && !rst_act_i) |=> addr_q == TERM);
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= TERM);
endmodule

// File: rtl/serial_cfg_rom_out.sv
module serial_cfg_rom_out
  import serial_cfg_rom_pkg::*;
#(
  parameter int unsigned DEPTH = 18144,
  parameter logic [31:0] SEED  = 32'h0,
  localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rst_act_i,
  input  logic          count_en_i,
  input  logic [AW-1:0] addr_i,
  output logic          data_q_o,
  output logic          valid_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o  <= 1'b0;
      valid_q_o <= 1'b0;
    end else if (rst_act_i) begin
      data_q_o  <= 1'b0;
      valid_q_o <= 1'b0;
    end else begin
      valid_q_o <= count_en_i;
      if (count_en_i) data_q_o <= rom_bit(32'(addr_i), SEED);
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && !rst_act_i) |=> valid_q_o);
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int unsigned DEPTH    = 18144,
  parameter logic [31:0] SEED     = 32'h0,
  parameter bit          RST_HIGH = 1'b1,
  localparam int unsigned AW      = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic rstoe_i,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no,
  output logic standby_o
);
  logic          ce_act, rst_act, done, count_en, data_q, valid_q;
  logic [AW-1:0] addr;

  serial_cfg_rom_ctrl #(.RST_HIGH(RST_HIGH)) u_ctrl (
    .ce_ni     (ce_ni),
    .rstoe_i   (rstoe_i),
    .ce_act_o  (ce_act),
    .rst_act_o (rst_act),
    .standby_o (standby_o)
  );

  serial_cfg_rom_addr #(.DEPTH(DEPTH)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_act_i   (ce_act),
    .rst_act_i  (rst_act),
    .addr_o     (addr),
    .done_o     (done),
    .count_en_o (count_en)
  );

  serial_cfg_rom_out #(.DEPTH(DEPTH), .SEED(SEED)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_act_i  (rst_act),
    .count_en_i (count_en),
    .addr_i     (addr),
    .data_q_o   (data_q),
    .valid_q_o  (valid_q)
  );

  assign data_oe_o = valid_q & ce_act & ~rst_act;
  assign data_o    = data_oe_o & data_q;
  assign ceo_no    = ~(ce_act & ~rst_act & done);

  p_ceo_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> (!ce_ni && !rst_act));
  p_standby_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!data_oe_o && ceo_no && standby_o));
  p_handoff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceo_no && !rst_act) |=> !data_oe_o);
  p_quiet_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> !data_o);
endmodule

// File: tb/serial_cfg_rom_tb.sv
module serial_cfg_rom_tb;
  localparam int unsigned D  = 40;
  localparam logic [31:0] S0 = 32'h1;
  localparam logic [31:0] S1 = 32'h5A;
  localparam logic [31:0] SP = 32'h3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1'b1, rstoe_c = 1'b0;
  logic ce_p_n = 1'b1, rstoe_p = 1'b1;
  logic d1, oe1, ceo1, sb1, d2, oe2, ceo2, sb2, dp, oep, ceop, sbp;
  int checks = 0, errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  serial_cfg_rom #(.DEPTH(D), .SEED(S0), .RST_HIGH(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce1_n), .rstoe_i(rstoe_c),
    .data_o(d1), .data_oe_o(oe1), .ceo_no(ceo1), .standby_o(sb1));
  serial_cfg_rom #(.DEPTH(D), .SEED(S1), .RST_HIGH(1'b0)) u_dut2 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ceo1), .rstoe_i(rstoe_c),
    .data_o(d2), .data_oe_o(oe2), .ceo_no(ceo2), .standby_o(sb2));
  serial_cfg_rom #(.DEPTH(8), .SEED(SP)) u_pol (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_p_n), .rstoe_i(rstoe_p),
    .data_o(dp), .data_oe_o(oep), .ceo_no(ceop), .standby_o(sbp));

  function automatic logic exp_bit(input int unsigned a, input logic [31:0] s);
    logic [31:0] v;
    v = 32'(a);
    return ^(v ^ (v >> 1) ^ s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R8, R9, R6: one bit of the chained stream at global index g
  task automatic chk_stream(input int unsigned g);
    logic e;
    e = (g < D) ? exp_bit(g, S0) : exp_bit(g - D, S1);
    chk((oe1 + oe2) == 1, "R6 single driver", oe1 + oe2, 1);
    chk((d1 | d2) == e, "R8/R9 stream bit", d1 | d2, e);
  endtask

  initial begin
    int unsigned g;
    bit pause;
    void'($urandom(32'd7));
    repeat (3) tick();
    // reset state, reset held by active-low rstoe
    chk(oe1 == 0 && oe2 == 0, "R2 reset oe", oe1 + oe2, 0);
    chk(ceo1 == 1, "R2 reset ceo", ceo1, 1);
    chk(sb1 == 1, "R3 standby", sb1, 1);
    rst_n = 1'b1;
    tick();
    ce1_n = 1'b0;
    tick();
    chk(oe1 == 0 && ceo1 == 1, "R2 held by rstoe", oe1, 0);
    rstoe_c = 1'b1;
    g = 0;
    // random pauses through the whole chain
    while (g < 2 * D) begin
      pause = (($urandom % 5) == 0) && g > 0;
      ce1_n = pause;
      tick();
      if (pause) begin
        chk(oe1 == 0 && oe2 == 0, "R3 paused quiet", oe1 + oe2, 0);
        chk(sb1 == 1 && ceo1 == 1, "R3 standby ceo", sb1 + ceo1, 2);
      end else begin
        chk_stream(g);  // also R7 after a pause, R1 advance
        g++;
        chk(ceo1 == (g < D), "R5 ceo1", ceo1, g < D);
      end
    end
    // R4: exhausted chain stays quiet
    ce1_n = 1'b0;
    repeat (3) begin
      tick();
      chk(oe1 == 0 && oe2 == 0, "R4 no more bits", oe1 + oe2, 0);
      chk(ceo2 == 0, "R5 ceo2 low", ceo2, 0);
    end
    // R3 then R5: raising ce releases chain
    ce1_n = 1'b1;
    #1;
    chk(ceo1 == 1 && ceo2 == 1, "R5 ceo follows ce", ceo1 + ceo2, 2);
    ce1_n = 1'b0;
    // R2: mid-life reset restarts at address 0
    rstoe_c = 1'b0;
    tick();
    chk(oe1 == 0 && ceo1 == 1, "R2 reset clears", ceo1, 1);
    rstoe_c = 1'b1;
    tick();
    chk_stream(0);
    tick();
    chk_stream(1);
    // polarity variant: active-high reset
    rstoe_p = 1'b1;
    ce_p_n = 1'b0;
    tick();
    chk(oep == 0, "R2 high polarity held", oep, 0);
    rstoe_p = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(oep == 1 && dp == exp_bit(i, SP), "R2 high polarity read", dp, exp_bit(i, SP));
    end
    rstoe_p = 1'b1;
    tick();
    rstoe_p = 1'b0;
    tick();
    chk(dp == exp_bit(0, SP) && oep == 1, "R2 restart at 0", dp, exp_bit(0, SP));
    for (int i = 1; i < 8; i++) tick();
    chk(ceop == 0, "R5 single device end", ceop, 0);
    tick();
    chk(oep == 0, "R6 oe drops after last", oep, 0);
    done_run = 1'b1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule